// File: doc/BRIEF.md
# EPROM Programming Sequencer

This block runs inside a device programmer and drives the parallel programming interface of a target microcontroller. A host hands it one command at a time over a valid/ready handshake. Each command carries an operation, a 13-bit target address and a data byte. The block places the address and data on the target's ports and sets the static mode-select pins for the operation. It then runs a timed sequence for the programming-voltage request and the active-low program strobe.

Write operations raise the voltage request first. The strobe is pulsed only while the request is high, and the request stays up for a hold time after the strobe. The block then waits a settle time before it reports. Read operations (verify and signature) never raise the request. They wait the settle time, sample the target's data bus and report the byte. Verify also reports whether the byte matches the expected value. Every accepted command returns exactly one single-cycle response. A divided clock for the target, with an enable, is produced all the time after reset.

Top module: `prog_seq`

## Requirements
- R1: The low 8 bits of an accepted address appear on `addr_lo` and the upper 5 bits on `addr_hi[4:0]`. Both stay stable until the next accepted, error-free command.
- R2: Write operations drive `cmd_data` on `data_out` with `data_oe` high during the command. Write operations are program code (0), encryption array (2) and lock bits 1/2/3 (3/4/5). Read operations, verify (1) and signature (6), keep `data_oe` low for the whole command.
- R3: A write command runs these phases after acceptance, in this order, and then responds:
  - the mode pins settle for `t_setup` cycles;
  - `vpp_req` is high for `t_setup` cycles before `prog_n` falls;
  - `prog_n` stays low for `t_pulse` cycles;
  - `vpp_req` stays high for `t_hold` cycles after `prog_n` rises;
  - after `vpp_req` falls, `t_settle` cycles pass before the response.

  `prog_n` is never low while `vpp_req` is low.
- R4: A read command never raises `vpp_req`. It samples `data_in` after `t_setup` plus `t_settle` cycles and responds in that cycle.
- R5: A verify response returns the sampled byte, with `rsp_pass` set when that byte equals `cmd_data` and cleared otherwise.
- R6: A signature read returns the sampled byte with `rsp_pass` set. A write response echoes `cmd_data` with `rsp_pass` set.
- R7: `sel_pins` bits are [0]=P2.6, [1]=P2.7, [2]=P3.3, [3]=P3.6 and [4]=P3.7. They take these values per operation:

  | Operation | Code | `sel_pins` |
  |---|---|---|
  | program code | 0 | 5'b11110 |
  | verify | 1 | 5'b11100 |
  | encryption | 2 | 5'b10110 |
  | lock 1 | 3 | 5'b11111 |
  | lock 2 | 4 | 5'b00111 |
  | lock 3 | 5 | 5'b01101 |
  | signature | 6 | 5'b00000 |
- R8: An encryption command with an address of 0x40 or above, or an operation code of 7, gets a response with `rsp_err` set in the acceptance cycle. Such a command leaves `addr_lo`, `addr_hi` and `sel_pins` unchanged and raises no voltage request.
- R9: `tgt_rst` is always high and `tgt_psen` always low.
- R10: `tgt_clk` has a period of 8 system clocks by default (6 MHz from 48 MHz), and `tgt_clk_en` is high after reset.
- R11: A timing input of 0 gives its phase a length of one cycle.
- R12: `cmd_ready` is high only while idle. `rsp_valid` is a one-cycle pulse, and there is exactly one response per accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low reset |
| cmd_valid | input | 1 | command offered |
| cmd_ready | output | 1 | command accepted when high with cmd_valid |
| cmd_mode | input | 3 | operation code |
| cmd_addr | input | 13 | target address |
| cmd_data | input | 8 | byte to write or expected verify byte |
| t_setup | input | 8 | mode-pin settle and voltage setup length |
| t_pulse | input | 8 | strobe low length |
| t_hold | input | 8 | voltage hold after strobe |
| t_settle | input | 8 | wait after voltage drop |
| data_in | input | 8 | target data bus read value |
| tgt_clk | output | 1 | divided target clock |
| tgt_clk_en | output | 1 | target clock enable |
| addr_lo | output | 8 | address bits 7:0 |
| addr_hi | output | 5 | address bits 12:8 |
| data_out | output | 8 | write byte |
| data_oe | output | 1 | data port drive enable |
| sel_pins | output | 5 | static mode-select pins |
| tgt_rst | output | 1 | target reset level |
| tgt_psen | output | 1 | target program-store enable level |
| prog_n | output | 1 | active-low program strobe |
| vpp_req | output | 1 | programming-voltage request |
| rsp_valid | output | 1 | response pulse |
| rsp_byte | output | 8 | sampled or echoed byte |
| rsp_pass | output | 1 | match or success |
| rsp_err | output | 1 | command rejected |

## Verification
Take S', P', H' and T' as the timing inputs with zero read as one. A write response is due 2S'+P'+H'+T' cycles after the acceptance edge, a read response S'+T' cycles after it, and an error response in the acceptance cycle itself. The voltage request must rise S' cycles after acceptance, and the strobe must fall S' cycles after that. The driver stores the acceptance cycle and the expected response in a queue entry. The monitor samples on falling clock edges, notes the cycles at which the request and the strobe change, and compares each gap and the response cycle with the entry it pops.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;
   localparam int SEL_W = 5;

   typedef enum logic [2:0] {
      OP_PCODE  = 3'd0,
      OP_VERIFY = 3'd1,
      OP_ENC    = 3'd2,
      OP_LOCK1  = 3'd3,
      OP_LOCK2  = 3'd4,
      OP_LOCK3  = 3'd5,
      OP_SIG    = 3'd6,
      OP_BAD    = 3'd7
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_SETUP, ST_VRAMP, ST_PULSE, ST_HOLD, ST_SETTLE, ST_RESP
   } st_e;

   function automatic logic op_writes(op_e op);
      return (op == OP_PCODE) || (op == OP_ENC) || (op == OP_LOCK1) ||
             (op == OP_LOCK2) || (op == OP_LOCK3);
   endfunction
endpackage

// File: rtl/prog_mode_pins.sv
module prog_mode_pins
   import prog_seq_pkg::*;
(
   input  op_e              op,
   output logic [SEL_W-1:0] sel
);
   always_comb begin
      case (op)
         OP_PCODE:  sel = 5'b11110;
         OP_VERIFY: sel = 5'b11100;
         OP_ENC:    sel = 5'b10110;
         OP_LOCK1:  sel = 5'b11111;
         OP_LOCK2:  sel = 5'b00111;
         OP_LOCK3:  sel = 5'b01101;
         default:   sel = 5'b00000;
      endcase
   end
endmodule

// File: rtl/prog_phase_timer.sv
module prog_phase_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic [CW-1:0] len,
   output logic          done
);
   logic [CW-1:0] cnt;

   assign done = ({1'b0, cnt} + {{CW{1'b0}}, 1'b1}) >= {1'b0, len};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (!done)   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/prog_tclk_gen.sv
module prog_tclk_gen #(
   parameter int HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tclk,
   output logic tclk_en
);
   localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tclk_en <= 1'b0;
      else        tclk_en <= 1'b1;
   end

   generate
      if (HALF == 1) begin : g_fast
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tclk <= 1'b0;
            else        tclk <= ~tclk;
         end
      end else begin : g_div
         logic [HW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt  <= '0;
               tclk <= 1'b0;
            end else if (cnt == HW'(HALF - 1)) begin
               cnt  <= '0;
               tclk <= ~tclk;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/prog_seq.sv
module prog_seq
   import prog_seq_pkg::*;
#(
   parameter int ADDR_W    = 13,
   parameter int LO_W      = 8,
   parameter int DATA_W    = 8,
   parameter int CW        = 8,
   parameter int ENC_DEPTH = 64,
   parameter int SYS_HZ    = 48_000_000,
   parameter int TGT_HZ    = 6_000_000
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_valid,
   output logic                   cmd_ready,
   input  logic [2:0]             cmd_mode,
   input  logic [ADDR_W-1:0]      cmd_addr,
   input  logic [DATA_W-1:0]      cmd_data,
   input  logic [CW-1:0]          t_setup,
   input  logic [CW-1:0]          t_pulse,
   input  logic [CW-1:0]          t_hold,
   input  logic [CW-1:0]          t_settle,
   input  logic [DATA_W-1:0]      data_in,
   output logic                   tgt_clk,
   output logic                   tgt_clk_en,
   output logic [LO_W-1:0]        addr_lo,
   output logic [ADDR_W-LO_W-1:0] addr_hi,
   output logic [DATA_W-1:0]      data_out,
   output logic                   data_oe,
   output logic [SEL_W-1:0]       sel_pins,
   output logic                   tgt_rst,
   output logic                   tgt_psen,
   output logic                   prog_n,
   output logic                   vpp_req,
   output logic                   rsp_valid,
   output logic [DATA_W-1:0]      rsp_byte,
   output logic                   rsp_pass,
   output logic                   rsp_err
);
   localparam int HI_W = ADDR_W - LO_W;
   localparam int HALF = SYS_HZ / (2 * TGT_HZ);
   localparam int TGT_F = SYS_HZ / (2 * ((HALF > 0) ? HALF : 1));
   localparam logic [ADDR_W-1:0] ENC_LIM = ADDR_W'(ENC_DEPTH);

   generate
      if (HI_W < 1) begin : g_bad_split
         $error("ADDR_W must exceed LO_W");
      end
      if (ENC_DEPTH < 1 || ENC_DEPTH >= (1 << ADDR_W)) begin : g_bad_enc
         $error("ENC_DEPTH out of address range");
      end
      if (HALF < 1 || TGT_F < 4_000_000 || TGT_F > 6_000_000) begin : g_bad_clk
         $error("target clock outside 4..6 MHz");
      end
      if (CW < 1) begin : g_bad_cw
         $error("CW must be positive");
      end
   endgenerate

   st_e              st, nxt;
   op_e              op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [SEL_W-1:0]  sel_dec;
   logic [CW-1:0]     len;
   logic              done;
   logic              accept, bad, wr;

   assign accept = (st == ST_IDLE) && cmd_valid;
   assign bad    = (op_e'(cmd_mode) == OP_BAD) ||
                   ((op_e'(cmd_mode) == OP_ENC) && (cmd_addr >= ENC_LIM));
   assign wr     = op_writes(op_q);

   prog_mode_pins u_pins (.op(op_e'(cmd_mode)), .sel(sel_dec));

   prog_phase_timer #(.CW(CW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .restart(nxt != st), .len(len), .done(done)
   );

   prog_tclk_gen #(.HALF(HALF)) u_tclk (
      .clk(clk), .rst_n(rst_n), .tclk(tgt_clk), .tclk_en(tgt_clk_en)
   );

   always_comb begin
      case (st)
         ST_SETUP, ST_VRAMP: len = t_setup;
         ST_PULSE:           len = t_pulse;
         ST_HOLD:            len = t_hold;
         ST_SETTLE:          len = t_settle;
         default:            len = '0;
      endcase
   end

   always_comb begin
      nxt = st;
      case (st)
         ST_IDLE:   if (cmd_valid) nxt = bad ? ST_RESP : ST_SETUP;
         ST_SETUP:  if (done) nxt = wr ? ST_VRAMP : ST_SETTLE;
         ST_VRAMP:  if (done) nxt = ST_PULSE;
         ST_PULSE:  if (done) nxt = ST_HOLD;
         ST_HOLD:   if (done) nxt = ST_SETTLE;
         ST_SETTLE: if (done) nxt = ST_RESP;
         ST_RESP:   nxt = ST_IDLE;
         default:   nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         op_q     <= OP_VERIFY;
         addr_q   <= '0;
         data_q   <= '0;
         sel_pins <= 5'b11100;
         rsp_byte <= '0;
         rsp_pass <= 1'b0;
         rsp_err  <= 1'b0;
      end else begin
         st <= nxt;
         if (accept) begin
            rsp_err <= bad;
            if (bad) begin
               rsp_byte <= '0;
               rsp_pass <= 1'b0;
            end else begin
               op_q     <= op_e'(cmd_mode);
               addr_q   <= cmd_addr;
               data_q   <= cmd_data;
               sel_pins <= sel_dec;
            end
         end
         if (st == ST_SETTLE && done) begin
            if (wr) begin
               rsp_byte <= data_q;
               rsp_pass <= 1'b1;
            end else begin
               rsp_byte <= data_in;
               rsp_pass <= (op_q == OP_VERIFY) ? (data_in == data_q) : 1'b1;
            end
         end
      end
   end

   assign cmd_ready = (st == ST_IDLE);
   assign addr_lo   = addr_q[LO_W-1:0];
   assign addr_hi   = addr_q[ADDR_W-1:LO_W];
   assign data_out  = data_q;
   assign data_oe   = wr && (st != ST_IDLE) && (st != ST_RESP);
   assign vpp_req   = (st == ST_VRAMP) || (st == ST_PULSE) || (st == ST_HOLD);
   assign prog_n    = (st != ST_PULSE);
   assign rsp_valid = (st == ST_RESP);
   assign tgt_rst   = 1'b1;
   assign tgt_psen  = 1'b0;
endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk #(
   parameter int LO_W   = 8,
   parameter int HI_W   = 5,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              prog_n,
   input logic              vpp_req,
   input logic              data_oe,
   input logic              cmd_ready,
   input logic              rsp_valid,
   input logic [LO_W-1:0]   addr_lo,
   input logic [HI_W-1:0]   addr_hi,
   input logic [DATA_W-1:0] data_out
);
   assert_strobe_under_vpp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_n |-> vpp_req);

   assert_vpp_leads_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prog_n) |-> $past(vpp_req));

   assert_oe_in_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_n |-> data_oe);

   assert_bus_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!prog_n && $past(!prog_n)) |-> ($stable(addr_lo) && $stable(addr_hi) && $stable(data_out)));

   assert_rsp_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_busy_no_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !cmd_ready);
endmodule

bind prog_seq prog_seq_chk #(.LO_W(LO_W), .HI_W(HI_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .vpp_req(vpp_req), .data_oe(data_oe),
   .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .addr_lo(addr_lo), .addr_hi(addr_hi),
   .data_out(data_out)
);

// File: tb/sim_prog_seq.sv
`timescale 1ns/1ps
module sim_prog_seq;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_ready;
   logic [2:0] cmd_mode = '0;
   logic [12:0] cmd_addr = '0;
   logic [7:0] cmd_data = '0, data_in = '0;
   logic [7:0] t_setup = 8'd1, t_pulse = 8'd1, t_hold = 8'd1, t_settle = 8'd1;
   logic tgt_clk, tgt_clk_en, data_oe, tgt_rst, tgt_psen, prog_n, vpp_req;
   logic [7:0] addr_lo, data_out, rsp_byte;
   logic [4:0] addr_hi, sel_pins;
   logic rsp_valid, rsp_pass, rsp_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   prog_seq u0 (.*);

   typedef struct {
      int a; int lat; logic bad; logic wr;
      logic [7:0] bval; logic pass; logic [4:0] sel; logic [12:0] addr;
      int s; int p; int h; int t;
   } exp_t;
   exp_t q[$];

   int checks = 0, errors = 0, cyc = 0;
   bit finished = 0;
   logic [12:0] last_addr = '0;
   logic [4:0]  last_sel = 5'b11100;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(string req, int act, int exp_v, string what);
      checks++;
      if (act != exp_v) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
      end
   endtask

   function automatic logic [4:0] sel_of(logic [2:0] m);
      case (m)
         3'd0: return 5'b11110;
         3'd1: return 5'b11100;
         3'd2: return 5'b10110;
         3'd3: return 5'b11111;
         3'd4: return 5'b00111;
         3'd5: return 5'b01101;
         default: return 5'b00000;
      endcase
   endfunction

   function automatic int eff(int v);
      return (v == 0) ? 1 : v;
   endfunction

   task automatic run(logic [2:0] m, logic [12:0] ad, logic [7:0] d, logic [7:0] din,
                      int s, int p, int h, int t);
      exp_t e;
      while (!cmd_ready) @(negedge clk);
      e.bad  = (m == 3'd7) || (m == 3'd2 && ad >= 13'h40);
      e.wr   = (m == 3'd0) || (m >= 3'd2 && m <= 3'd5);
      e.s = eff(s); e.p = eff(p); e.h = eff(h); e.t = eff(t);
      e.lat  = e.bad ? 0 : (e.wr ? 2*e.s + e.p + e.h + e.t : e.s + e.t);
      e.a    = cyc + 1;
      e.bval = e.wr ? d : din;
      e.pass = e.wr || m == 3'd6 || din == d;
      e.sel  = e.bad ? last_sel : sel_of(m);
      e.addr = e.bad ? last_addr : ad;
      if (!e.bad) begin last_sel = e.sel; last_addr = ad; end
      q.push_back(e);
      cmd_mode = m; cmd_addr = ad; cmd_data = d; data_in = din;
      t_setup = 8'(s); t_pulse = 8'(p); t_hold = 8'(h); t_settle = 8'(t);
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (q.size() != 0) @(negedge clk);
   endtask

   int vr = 0, vf = 0, pf = 0, pr = 0;
   bit pv = 0, pp = 1, saw_vpp = 0, saw_oe = 0;
   always @(negedge clk) if (rst_n) begin
      if (vpp_req && !pv) vr = cyc;
      if (!vpp_req && pv) vf = cyc;
      if (!prog_n && pp)  pf = cyc;
      if (prog_n && !pp)  pr = cyc;
      if (vpp_req) saw_vpp = 1;
      if (!cmd_ready && !rsp_valid && data_oe) saw_oe = 1;
      if (rsp_valid) begin
         if (q.size() == 0) begin
            chk("R12", 1, 0, "response without command");
         end else begin
            exp_t e;
            e = q.pop_front();
            chk("R12", cyc - e.a, e.lat, "response cycle");
            chk("R1", {addr_hi, addr_lo}, e.addr, "address pins");
            chk("R7", sel_pins, e.sel, "mode pins");
            if (e.bad) begin
               chk("R8", rsp_err, 1, "error flag");
               chk("R8", saw_vpp, 0, "vpp on rejected command");
            end else begin
               chk("R8", rsp_err, 0, "error flag");
               chk(e.wr ? "R6" : "R5", rsp_byte, e.bval, "response byte");
               chk(e.wr ? "R6" : "R5", rsp_pass, e.pass, "pass flag");
               chk("R2", saw_oe, e.wr, "data drive enable");
               if (e.wr) begin
                  chk("R2", data_out, e.bval, "data port");
                  chk("R3", vr - e.a, e.s, "pin settle before vpp");
                  chk("R3", pf - vr, e.s, "vpp setup before strobe");
                  chk("R3", pr - pf, e.p, "strobe width");
                  chk("R3", vf - pr, e.h, "vpp hold");
                  chk("R3", cyc - vf, e.t, "settle after vpp");
               end else begin
                  chk("R4", saw_vpp, 0, "vpp on read");
               end
            end
         end
         saw_vpp = 0; saw_oe = 0;
      end
      pv = vpp_req; pp = prog_n;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int r1, r2;
      bit pt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12", cmd_ready, 1, "ready after reset");
      chk("R3", prog_n, 1, "strobe idle after reset");
      chk("R3", vpp_req, 0, "vpp idle after reset");
      chk("R2", data_oe, 0, "oe after reset");
      chk("R12", rsp_valid, 0, "no response after reset");
      chk("R9", tgt_rst, 1, "target reset level");
      chk("R9", tgt_psen, 0, "target psen level");
      chk("R10", tgt_clk_en, 1, "target clock enable");
      // R10: period of the target clock between two rising edges
      r1 = -1; r2 = -1; pt = tgt_clk;
      for (int i = 0; i < 40 && r2 < 0; i++) begin
         @(negedge clk);
         if (tgt_clk && !pt) begin if (r1 < 0) r1 = cyc; else r2 = cyc; end
         pt = tgt_clk;
      end
      chk("R10", r2 - r1, 8, "target clock period");

      run(3'd0, 13'h1ABC, 8'h5A, 8'h00, 3, 5, 2, 4);   // program code
      run(3'd1, 13'h1ABC, 8'h5A, 8'h5A, 3, 5, 2, 4);   // verify match R5
      run(3'd1, 13'h0123, 8'h5A, 8'h5B, 2, 5, 2, 3);   // verify mismatch R5
      run(3'd2, 13'h003F, 8'hC3, 8'h00, 2, 4, 3, 2);   // encryption top address
      run(3'd2, 13'h0040, 8'hC3, 8'h00, 2, 4, 3, 2);   // R8 out of range
      run(3'd3, 13'h0000, 8'hFF, 8'h00, 1, 2, 1, 1);   // lock 1
      run(3'd4, 13'h0000, 8'hFF, 8'h00, 2, 3, 2, 2);   // lock 2
      run(3'd5, 13'h0000, 8'hFF, 8'h00, 4, 1, 5, 3);   // lock 3
      run(3'd6, 13'h0031, 8'h00, 8'h1E, 3, 0, 0, 5);   // R6 signature
      run(3'd7, 13'h1555, 8'h11, 8'h00, 3, 3, 3, 3);   // R8 bad op
      run(3'd0, 13'h1FFF, 8'hA5, 8'h00, 0, 0, 0, 0);   // R11 zero lengths
      run(3'd6, 13'h0030, 8'h00, 8'h95, 0, 0, 0, 7);   // R11 read, zero setup
      repeat (3) @(negedge clk);
      chk("R12", q.size(), 0, "all responses seen");
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule